// File: doc/BRIEF.md
# Bit-sliced banked word memory

This block is an eight-word, four-bit memory assembled from four small banks. Each bank stores four two-bit words in its own cell array, with a row decoder that raises one word line, a write gate that lets a cell capture data only while its word line, the write strobe and the bank's chip select are all high, and an output gate that lets the bank drive its data only while output enable and chip select are both high. Banks work in pairs. One bank of a pair holds bits 1:0 of every word, and its partner holds bits 3:2. Both banks of a pair share one chip select.

The wrapper takes a system address, write data, a write request and a read request. It turns the address into a pair select and a row address, and it merges the outputs of the selected pair into the read word. A parameter picks how the address is split. In high-order mode, address bit 2 chooses the pair, so words 0 to 3 sit in pair 0 and words 4 to 7 in pair 1. In low-order mode, address bit 0 chooses the pair, so neighbouring addresses land in different pairs. The per-pair chip-select lines are brought out so that the mapping can be seen from outside.

Top module: `banked_word_mem`

## Requirements
- R1: After reset, every one of the eight words reads back as zero.
- R2: When wr_req is high at a rising clock edge, wr_data is stored at sys_addr. A later read of that address with rd_req high and wr_req low returns it combinationally, within the same cycle as the request.
- R3: Bits 1:0 and bits 3:2 of a word are stored independently. A write to one address leaves every other address unchanged.
- R4: With LOW_ORDER=0, an active request drives pair_sel to 1 << sys_addr[2]. Bit 0 of pair_sel is pair 0.
- R5: With LOW_ORDER=1, an active request drives pair_sel to 1 << sys_addr[0].
- R6: pair_sel has exactly one bit set while wr_req or rd_req is high, and it is all zeros while both are low.
- R7: rd_data is zero whenever rd_req is low, whatever the stored contents.
- R8: When rd_req and wr_req are high together, the cycle acts as a write: the data is stored exactly as in R2.
- R9: While wr_req is low, changes on wr_data and sys_addr leave every stored word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes take effect on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset; clears all cells |
| sys_addr | input | 3 | System word address |
| wr_data | input | 4 | Word to be written |
| wr_req | input | 1 | Write request |
| rd_req | input | 1 | Read request |
| rd_data | output | 4 | Read word; zero when no pair drives |
| pair_sel | output | 2 | Chip-select line of each bank pair |

## Verification
Two instances, one in each interleave mode, receive identical stimulus. Every address is written and read back with address-derived values, with their complements, and with all-ones and all-zeros fills. Each of these patterns shows up a different fault: a slice swap, a stuck bit or a wrong row. Single-address overwrites followed by full sweeps expose any write that spills into a neighbouring row or pair. The pair_sel sweep over all eight addresses separates the two interleave mappings. Idle cycles with toggling data, and cycles that raise both strobes at once, confirm the gating of writes and output drive.

// File: rtl/bmem_pkg.sv
package bmem_pkg;

    // Control lines that reach one bank
    typedef struct packed {
        logic cs;   // chip select
        logic we;   // write strobe
        logic oe;   // output enable
    } bank_ctl_t;

endpackage

// File: rtl/bmem_row_decoder.sv
module bmem_row_decoder #(
    parameter int ROW_AW = 2
) (
    input  logic [ROW_AW-1:0]      row_addr,
    output logic [(1<<ROW_AW)-1:0] word_line
);
    localparam int ROWS = 1 << ROW_AW;

    // one comparator per row; exactly one line high
    for (genvar r = 0; r < ROWS; r++) begin : g_line
        assign word_line[r] = (row_addr == ROW_AW'(r));
    end
endmodule

// File: rtl/bmem_bank.sv
module bmem_bank
    import bmem_pkg::*;
#(
    parameter int ROWS    = 4,
    parameter int SLICE_W = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [$clog2(ROWS)-1:0]  row_addr,
    input  logic [SLICE_W-1:0]       din,
    input  bank_ctl_t                ctl,
    output logic [SLICE_W-1:0]       dout,
    output logic                     drive
);
    localparam int ROW_AW = $clog2(ROWS);

    typedef struct packed {
        logic [ROWS-1:0][SLICE_W-1:0] cells;
    } bank_state_t;

    bank_state_t             st_d, st_q;
    logic [ROWS-1:0]         word_line;

    bmem_row_decoder #(.ROW_AW(ROW_AW)) u_dec (
        .row_addr  (row_addr),
        .word_line (word_line)
    );

    // gated write: word line, strobe and chip select together
    always_comb begin
        st_d = st_q;
        for (int r = 0; r < ROWS; r++) begin
            if (word_line[r] && ctl.we && ctl.cs) begin
                st_d.cells[r] = din;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // gated output: enable and chip select together
    always_comb begin
        drive = ctl.oe & ctl.cs;
        dout  = '0;
        if (drive) begin
            for (int r = 0; r < ROWS; r++) begin
                if (word_line[r]) begin
                    dout = dout | st_q.cells[r];
                end
            end
        end
    end
endmodule

// File: rtl/bmem_pair_map.sv
module bmem_pair_map #(
    parameter int PAIR_AW   = 1,
    parameter int ROW_AW    = 2,
    parameter bit LOW_ORDER = 1'b0
) (
    input  logic [PAIR_AW+ROW_AW-1:0] sys_addr,
    input  logic                      active,
    output logic [(1<<PAIR_AW)-1:0]   pair_sel,
    output logic [ROW_AW-1:0]         row_addr
);
    localparam int AW    = PAIR_AW + ROW_AW;
    localparam int PAIRS = 1 << PAIR_AW;

    logic [PAIR_AW-1:0] pair_idx;

    if (LOW_ORDER) begin : g_low
        assign pair_idx = sys_addr[PAIR_AW-1:0];
        assign row_addr = sys_addr[AW-1:PAIR_AW];
    end else begin : g_high
        assign pair_idx = sys_addr[AW-1:ROW_AW];
        assign row_addr = sys_addr[ROW_AW-1:0];
    end

    for (genvar p = 0; p < PAIRS; p++) begin : g_cs
        assign pair_sel[p] = active && (pair_idx == PAIR_AW'(p));
    end
endmodule

// File: rtl/banked_word_mem.sv
module banked_word_mem
    import bmem_pkg::*;
#(
    parameter int ROWS      = 4,
    parameter int SLICE_W   = 2,
    parameter int SLICES    = 2,
    parameter int PAIRS     = 2,
    parameter bit LOW_ORDER = 1'b0
) (
    input  logic                                        clk,
    input  logic                                        rst_n,
    input  logic [$clog2(PAIRS)+$clog2(ROWS)-1:0]       sys_addr,
    input  logic [SLICE_W*SLICES-1:0]                   wr_data,
    input  logic                                        wr_req,
    input  logic                                        rd_req,
    output logic [SLICE_W*SLICES-1:0]                   rd_data,
    output logic [PAIRS-1:0]                            pair_sel
);
    localparam int ROW_AW  = $clog2(ROWS);
    localparam int PAIR_AW = $clog2(PAIRS);
    localparam int AW      = PAIR_AW + ROW_AW;
    localparam int DW      = SLICE_W * SLICES;

    logic                                     active;
    logic                                     rd_gate;
    logic [ROW_AW-1:0]                        row_addr;
    logic [PAIRS-1:0][SLICES-1:0][SLICE_W-1:0] slice_out;
    logic [PAIRS-1:0][SLICES-1:0]             slice_drv;

    assign active  = wr_req | rd_req;
    assign rd_gate = rd_req & ~wr_req;   // write wins when both are high

    bmem_pair_map #(
        .PAIR_AW   (PAIR_AW),
        .ROW_AW    (ROW_AW),
        .LOW_ORDER (LOW_ORDER)
    ) u_map (
        .sys_addr (sys_addr),
        .active   (active),
        .pair_sel (pair_sel),
        .row_addr (row_addr)
    );

    for (genvar p = 0; p < PAIRS; p++) begin : g_pair
        bank_ctl_t ctl;
        assign ctl.cs = pair_sel[p];
        assign ctl.we = wr_req;
        assign ctl.oe = rd_gate;
        for (genvar s = 0; s < SLICES; s++) begin : g_slice
            bmem_bank #(
                .ROWS    (ROWS),
                .SLICE_W (SLICE_W)
            ) u_bank (
                .clk      (clk),
                .rst_n    (rst_n),
                .row_addr (row_addr),
                .din      (wr_data[s*SLICE_W +: SLICE_W]),
                .ctl      (ctl),
                .dout     (slice_out[p][s]),
                .drive    (slice_drv[p][s])
            );
        end
    end

    // merge the driven slices into the read word
    always_comb begin
        rd_data = '0;
        for (int p = 0; p < PAIRS; p++) begin
            for (int s = 0; s < SLICES; s++) begin
                if (slice_drv[p][s]) begin
                    rd_data[s*SLICE_W +: SLICE_W] = rd_data[s*SLICE_W +: SLICE_W] | slice_out[p][s];
                end
            end
        end
    end
endmodule

// File: rtl/bmem_checks.sv
module bmem_checks #(
    parameter int AW    = 3,
    parameter int DW    = 4,
    parameter int PAIRS = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] sys_addr,
    input logic [DW-1:0] wr_data,
    input logic          wr_req,
    input logic          rd_req,
    input logic [DW-1:0] rd_data,
    input logic [PAIRS-1:0] pair_sel
);
    // R6: one pair selected per active request
    p_one_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req || rd_req) |-> ($countones(pair_sel) == 1));

    // R6: no pair selected while idle
    p_idle_no_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_req && !rd_req) |-> (pair_sel == '0));

    // R7: no read request, no data
    p_quiet_output_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |-> (rd_data == '0));

    // R2: a write is seen by a read of the same address in the next cycle
    p_write_readback_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_req) && rd_req && !wr_req && sys_addr == $past(sys_addr))
        |-> (rd_data == $past(wr_data)));

    // R9: with no write, a steady read stays steady
    p_hold_without_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(wr_req) && $past(rd_req) && rd_req && !wr_req && $stable(sys_addr))
        |-> $stable(rd_data));
endmodule

bind banked_word_mem bmem_checks #(
    .AW    (AW),
    .DW    (DW),
    .PAIRS (PAIRS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sys_addr (sys_addr),
    .wr_data  (wr_data),
    .wr_req   (wr_req),
    .rd_req   (rd_req),
    .rd_data  (rd_data),
    .pair_sel (pair_sel)
);

// File: tb/sim_banked_word_mem.sv
module sim_banked_word_mem;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] sys_addr = '0;
    logic [3:0] wr_data = '0;
    logic       wr_req = 1'b0;
    logic       rd_req = 1'b0;
    logic [3:0] rd_hi, rd_lo;
    logic [1:0] sel_hi, sel_lo;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 1'b0;
    logic [3:0] model [8];

    always #2 clk = ~clk;   // 250 MHz

    banked_word_mem #(.LOW_ORDER(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .sys_addr(sys_addr), .wr_data(wr_data),
        .wr_req(wr_req), .rd_req(rd_req), .rd_data(rd_hi), .pair_sel(sel_hi));

    banked_word_mem #(.LOW_ORDER(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .sys_addr(sys_addr), .wr_data(wr_data),
        .wr_req(wr_req), .rd_req(rd_req), .rd_data(rd_lo), .pair_sel(sel_lo));

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
            finish_run();
        end
    end

    task automatic do_write(input int a, input int d, input bit with_rd);
        @(negedge clk);
        sys_addr = 3'(a); wr_data = 4'(d); wr_req = 1'b1; rd_req = with_rd;
        #1;
        check("R6 write pair_sel count", $countones(sel_hi), 1);
        @(negedge clk);
        wr_req = 1'b0; rd_req = 1'b0;
        model[a] = 4'(d);
    endtask

    task automatic read_all(input string req);
        for (int a = 0; a < 8; a++) begin
            @(negedge clk);
            sys_addr = 3'(a); rd_req = 1'b1;
            #1;
            check(req, rd_hi, model[a]);
            check(req, rd_lo, model[a]);
        end
        @(negedge clk);
        rd_req = 1'b0;
    endtask

    initial begin
        for (int a = 0; a < 8; a++) model[a] = 4'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: cleared contents
        read_all("R1 reset contents");

        // R6: idle select lines
        #1;
        check("R6 idle pair_sel hi", sel_hi, 0);
        check("R6 idle pair_sel lo", sel_lo, 0);

        // R4 / R5: mapping sweep
        for (int a = 0; a < 8; a++) begin
            @(negedge clk);
            sys_addr = 3'(a); rd_req = 1'b1;
            #1;
            check("R4 high-order pair_sel", sel_hi, 1 << ((a >> 2) & 1));
            check("R5 low-order pair_sel", sel_lo, 1 << (a & 1));
        end
        @(negedge clk);
        rd_req = 1'b0;

        // R2 / R3: address-derived pattern, then complement
        for (int a = 0; a < 8; a++) do_write(a, (a * 5 + 3) & 15, 1'b0);
        read_all("R2 pattern readback");
        for (int a = 0; a < 8; a++) do_write(a, ~((a * 5 + 3)) & 15, 1'b0);
        read_all("R3 complement readback");

        // R3: single overwrite must not disturb neighbours
        do_write(2, 4'hF, 1'b0);
        read_all("R3 isolation after addr 2");
        do_write(5, 4'h0, 1'b0);
        read_all("R3 isolation after addr 5");

        // R3: slices independent (only high or low bits set)
        do_write(6, 4'hC, 1'b0);
        do_write(1, 4'h3, 1'b0);
        read_all("R3 slice split");

        // R7: no read request gives zero output
        @(negedge clk);
        sys_addr = 3'd2; rd_req = 1'b0;
        #1;
        check("R7 rd_data idle hi", rd_hi, 0);
        check("R7 rd_data idle lo", rd_lo, 0);

        // R9: idle cycles with changing data and address
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            sys_addr = 3'(k); wr_data = 4'(k ^ 4'hA); wr_req = 1'b0;
        end
        read_all("R9 no write while wr_req low");

        // R8: both strobes high acts as a write
        do_write(5, 4'hA, 1'b1);
        do_write(0, 4'h6, 1'b1);
        read_all("R8 simultaneous strobes write");

        // fills
        for (int a = 0; a < 8; a++) do_write(a, 4'hF, 1'b0);
        read_all("R2 all ones");
        for (int a = 0; a < 8; a++) do_write(a, 4'h0, 1'b0);
        read_all("R2 all zeros");

        finish_run();
    end
endmodule